// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block keeps a bank of transmit mailboxes for a CAN controller. Software fills each mailbox through a flat register interface: an identifier word that carries the format bits, a data length code and eight separate payload byte registers. It then marks the mailbox as pending. The scheduler picks one pending mailbox at a time and locks it. It offers that frame on a valid/ready port to the bit-level transmitter. It then waits for a success or abort result, and on that result it updates the per-mailbox acknowledge flags.

A single mode bit chooses the sending order. In one mode the frame that would win bus arbitration goes first. In the other mode the lowest-numbered mailbox goes first. The payload offered to the transmitter is cut to the length given by the data length code. A maskable interrupt summarises the acknowledge flags, and each mailbox has its own mask bit.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset the pending, success-flag, abort-flag and mask registers read 0, the mode is identifier priority, mailbox registers read 0, `tx_valid` is low and `irq` is low.
- R2: The register address is {mailbox[3:0], field[3:0]}. At mailbox 0, field 0 is the pending register: writing 1 to bit n (n = 1..NUM_MB) marks mailbox n pending, and writing 0 to a bit leaves it unchanged. Field 5 bit 0 is the mode bit.
- R3: With the mode bit set to 1, the lowest-numbered pending mailbox is offered first.
- R4: With the mode bit at 0, the mailbox with the lowest arbitration key is offered first, and a tie goes to the lower mailbox number. The identifier word (mailbox field 0) holds the identifier in bits 28:0, with the base in bits 28:18 and the extension in bits 17:0, RTR in bit 29 and IDE in bit 30. The key is {base, RTR, 0, 18 zeros, 0} for a standard frame and {base, 1, 1, extension, RTR} for an extended frame.
- R5: Mailbox field 1 bits 3:0 hold the data length code, and fields 2..9 hold payload bytes 0..7. `tx_len` is min(code, 8). `tx_data` byte k (bits 8k+7:8k) carries the stored byte when k < `tx_len` and is 0 otherwise. `tx_dlc` carries the raw code.
- R6: An offered frame keeps `tx_valid` and all its fields steady until `tx_ready`. The mailbox stays locked and nothing else is offered until a result arrives.
- R7: A result with `res_ok`=1 clears the locked mailbox's pending bit and sets its bit in the success-flag register (mailbox 0, field 2).
- R8: A result with `res_ok`=0 clears the locked mailbox's pending bit and sets its bit in the abort-flag register (mailbox 0, field 3).
- R9: Writing 1 to bit n of the abort request register (mailbox 0, field 1) clears pending bit n and sets abort flag n, unless mailbox n is locked. In that case the write has no effect on mailbox n.
- R10: `irq` is the OR of all success and abort flags whose mask bit (mailbox 0, field 4) is 0.
- R11: Writing 1 to a bit of either flag register clears that flag, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | MB_W+4 | Write address {mailbox, field} |
| wr_data | input | 32 | Write data |
| rd_addr | input | MB_W+4 | Read address {mailbox, field} |
| rd_data | output | 32 | Read data (combinational) |
| tx_valid | output | 1 | Frame offered to transmitter |
| tx_ready | input | 1 | Transmitter accepts the frame |
| tx_mbox | output | MB_W | Number of the offered mailbox |
| tx_id | output | 29 | Identifier, base in 28:18 |
| tx_ide | output | 1 | Extended-format bit |
| tx_rtr | output | 1 | Remote request bit |
| tx_dlc | output | 4 | Raw data length code |
| tx_len | output | 4 | Payload byte count, capped at 8 |
| tx_data | output | 64 | Payload, unused bytes zero |
| res_valid | input | 1 | Transmission result strobe |
| res_ok | input | 1 | 1 = sent, 0 = aborted |
| irq | output | 1 | Unmasked acknowledge interrupt |

## Verification
The bench builds the block with the default of fifteen mailboxes, so every mailbox number and every pending bit is reachable. It sweeps all sixteen data length codes on one mailbox, which covers each truncation length and every code above eight. It drains all fifteen mailboxes in both ordering modes. In identifier mode the identifiers mix standard and extended frames, repeat base values, and include one exact tie.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
   localparam int ID_W      = 29;
   localparam int BASE_W    = 11;
   localparam int EXT_W     = 18;
   localparam int KEY_W     = 32;
   localparam int BYTE_W    = 8;
   localparam int MAX_BYTES = 8;
   localparam int FIELD_W   = 4;
   localparam int REG_W     = 32;
   localparam int DLC_W     = 4;

   typedef enum logic [FIELD_W-1:0] {
      GF_PEND   = 4'd0,
      GF_ABORT  = 4'd1,
      GF_OKFLG  = 4'd2,
      GF_ABFLG  = 4'd3,
      GF_MASK   = 4'd4,
      GF_MODE   = 4'd5
   } glob_field_e;

   localparam logic [FIELD_W-1:0] MF_IDW  = 4'd0;
   localparam logic [FIELD_W-1:0] MF_DLC  = 4'd1;
   localparam logic [FIELD_W-1:0] MF_DAT0 = 4'd2;
   localparam logic [FIELD_W-1:0] MF_DAT7 = 4'd9;

   // Arbitration key in on-wire bit order, lower value wins.
   function automatic logic [KEY_W-1:0] wire_key(input logic [ID_W-1:0] id,
                                                 input logic ide, input logic rtr);
      logic [KEY_W-1:0] k;
      if (ide) k = {id[ID_W-1:EXT_W], 1'b1, 1'b1, id[EXT_W-1:0], rtr};
      else     k = {id[ID_W-1:EXT_W], rtr, 1'b0, {EXT_W{1'b0}}, 1'b0};
      return k;
   endfunction
endpackage

// File: rtl/can_txmb_store.sv
module can_txmb_store
   import can_txmb_pkg::*;
#(
   parameter int NUM_MB = 15,
   parameter int MB_W   = 4
)(
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [MB_W-1:0]                        wr_mb,
   input  logic [FIELD_W-1:0]                     wr_fld,
   input  logic [REG_W-1:0]                       wr_data,
   input  logic [MB_W-1:0]                        rd_mb,
   input  logic [FIELD_W-1:0]                     rd_fld,
   output logic [REG_W-1:0]                       rd_data,
   output logic [NUM_MB:1][ID_W-1:0]              id_a,
   output logic [NUM_MB:1]                        ide_a,
   output logic [NUM_MB:1]                        rtr_a,
   output logic [NUM_MB:1][DLC_W-1:0]             dlc_a,
   output logic [NUM_MB:1][MAX_BYTES-1:0][BYTE_W-1:0] dat_a
);
   localparam int BSEL_W = $clog2(MAX_BYTES);

   logic [FIELD_W-1:0] wr_off, rd_off;
   assign wr_off = wr_fld - MF_DAT0;
   assign rd_off = rd_fld - MF_DAT0;

   for (genvar m = 1; m <= NUM_MB; m++) begin : g_mb
      logic hit;
      assign hit = wr_en && (wr_mb == MB_W'(m));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            id_a[m]  <= '0;
            ide_a[m] <= 1'b0;
            rtr_a[m] <= 1'b0;
            dlc_a[m] <= '0;
            dat_a[m] <= '0;
         end else if (hit) begin
            if (wr_fld == MF_IDW) begin
               id_a[m]  <= wr_data[ID_W-1:0];
               rtr_a[m] <= wr_data[ID_W];
               ide_a[m] <= wr_data[ID_W+1];
            end else if (wr_fld == MF_DLC) begin
               dlc_a[m] <= wr_data[DLC_W-1:0];
            end else if (wr_fld >= MF_DAT0 && wr_fld <= MF_DAT7) begin
               dat_a[m][wr_off[BSEL_W-1:0]] <= wr_data[BYTE_W-1:0];
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int m = 1; m <= NUM_MB; m++) begin
         if (rd_mb == MB_W'(m)) begin
            if (rd_fld == MF_IDW)
               rd_data = REG_W'({ide_a[m], rtr_a[m], id_a[m]});
            else if (rd_fld == MF_DLC)
               rd_data = REG_W'(dlc_a[m]);
            else if (rd_fld >= MF_DAT0 && rd_fld <= MF_DAT7)
               rd_data = REG_W'(dat_a[m][rd_off[BSEL_W-1:0]]);
         end
      end
   end
endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb
   import can_txmb_pkg::*;
#(
   parameter int NUM_MB = 15,
   parameter int MB_W   = 4
)(
   input  logic [NUM_MB:1]             pend,
   input  logic [NUM_MB:1][KEY_W-1:0]  key,
   input  logic                        by_number,
   output logic                        any,
   output logic [MB_W-1:0]             sel
);
   logic [NUM_MB:1][KEY_W-1:0] eff_key;

   // Number order: all keys equal so the lowest index wins the tie rule.
   for (genvar m = 1; m <= NUM_MB; m++) begin : g_key
      assign eff_key[m] = by_number ? '0 : key[m];
   end

   always_comb begin
      logic [KEY_W-1:0] best;
      best = '1;
      any  = 1'b0;
      sel  = '0;
      for (int m = 1; m <= NUM_MB; m++) begin
         if (pend[m] && (!any || eff_key[m] < best)) begin
            any  = 1'b1;
            best = eff_key[m];
            sel  = MB_W'(m);
         end
      end
   end
endmodule

// File: rtl/can_txmb_trunc.sv
module can_txmb_trunc
   import can_txmb_pkg::*;
(
   input  logic [DLC_W-1:0]                       dlc,
   input  logic [MAX_BYTES-1:0][BYTE_W-1:0]       dat_in,
   output logic [DLC_W-1:0]                       len,
   output logic [MAX_BYTES*BYTE_W-1:0]            dat_out
);
   assign len = (dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc;

   for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
      assign dat_out[b*BYTE_W +: BYTE_W] = (DLC_W'(b) < len) ? dat_in[b] : '0;
   end
endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
   import can_txmb_pkg::*;
#(
   parameter  int NUM_MB = 15,
   localparam int MB_W   = $clog2(NUM_MB + 1),
   localparam int ADDR_W = MB_W + FIELD_W
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [REG_W-1:0]              wr_data,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [REG_W-1:0]              rd_data,
   output logic                          tx_valid,
   input  logic                          tx_ready,
   output logic [MB_W-1:0]               tx_mbox,
   output logic [ID_W-1:0]               tx_id,
   output logic                          tx_ide,
   output logic                          tx_rtr,
   output logic [DLC_W-1:0]              tx_dlc,
   output logic [DLC_W-1:0]              tx_len,
   output logic [MAX_BYTES*BYTE_W-1:0]   tx_data,
   input  logic                          res_valid,
   input  logic                          res_ok,
   output logic                          irq
);
   if (NUM_MB < 1 || NUM_MB > 15) begin : g_bad_num
      $error("can_txmb_sched: NUM_MB must lie in 1..15");
   end
   if (REG_W < ID_W + 2) begin : g_bad_reg
      $error("can_txmb_sched: register word too narrow for identifier word");
   end

   logic [MB_W-1:0]    wr_mb, rd_mb;
   logic [FIELD_W-1:0] wr_fld, rd_fld;
   assign wr_mb  = wr_addr[ADDR_W-1:FIELD_W];
   assign wr_fld = wr_addr[FIELD_W-1:0];
   assign rd_mb  = rd_addr[ADDR_W-1:FIELD_W];
   assign rd_fld = rd_addr[FIELD_W-1:0];

   logic [NUM_MB:1][ID_W-1:0]                 id_a;
   logic [NUM_MB:1]                           ide_a, rtr_a;
   logic [NUM_MB:1][DLC_W-1:0]                dlc_a;
   logic [NUM_MB:1][MAX_BYTES-1:0][BYTE_W-1:0] dat_a;
   logic [NUM_MB:1][KEY_W-1:0]                key_a;
   logic [REG_W-1:0]                          mb_rd;

   can_txmb_store #(.NUM_MB(NUM_MB), .MB_W(MB_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_mb(wr_mb), .wr_fld(wr_fld), .wr_data(wr_data),
      .rd_mb(rd_mb), .rd_fld(rd_fld), .rd_data(mb_rd),
      .id_a(id_a), .ide_a(ide_a), .rtr_a(rtr_a), .dlc_a(dlc_a), .dat_a(dat_a)
   );

   for (genvar m = 1; m <= NUM_MB; m++) begin : g_keys
      assign key_a[m] = wire_key(id_a[m], ide_a[m], rtr_a[m]);
   end

   // Control state
   logic [NUM_MB:1] pend_q, okflg_q, abflg_q, mask_q;
   logic            mode_q, busy_q, sent_q;
   logic [MB_W-1:0] cur_q, sel;
   logic            any;

   can_txmb_arb #(.NUM_MB(NUM_MB), .MB_W(MB_W)) u_arb (
      .pend(pend_q), .key(key_a), .by_number(mode_q), .any(any), .sel(sel)
   );

   logic            gwr;
   logic [NUM_MB:1] wbits, cur_oh, sel_oh, lock_vec;
   logic [NUM_MB:1] ok_vec, bad_vec, abort_eff, pend_set, okclr, abclr;
   logic            fin;

   assign gwr   = wr_en && (wr_mb == '0);
   assign wbits = wr_data[NUM_MB:1];
   assign fin   = busy_q && sent_q && res_valid;

   for (genvar m = 1; m <= NUM_MB; m++) begin : g_oh
      assign cur_oh[m] = (cur_q == MB_W'(m));
      assign sel_oh[m] = (sel == MB_W'(m));
   end

   assign lock_vec  = busy_q ? cur_oh : (any ? sel_oh : '0);
   assign ok_vec    = (fin &&  res_ok) ? cur_oh : '0;
   assign bad_vec   = (fin && !res_ok) ? cur_oh : '0;
   assign abort_eff = (gwr && wr_fld == GF_ABORT) ? (wbits & ~lock_vec) : '0;
   assign pend_set  = (gwr && wr_fld == GF_PEND)  ? wbits : '0;
   assign okclr     = (gwr && wr_fld == GF_OKFLG) ? wbits : '0;
   assign abclr     = (gwr && wr_fld == GF_ABFLG) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         okflg_q <= '0;
         abflg_q <= '0;
         mask_q  <= '0;
         mode_q  <= 1'b0;
      end else begin
         pend_q  <= (pend_q & ~(ok_vec | bad_vec | abort_eff)) | pend_set;
         okflg_q <= (okflg_q & ~okclr) | ok_vec;
         abflg_q <= (abflg_q & ~abclr) | bad_vec | abort_eff;
         if (gwr && wr_fld == GF_MASK) mask_q <= wbits;
         if (gwr && wr_fld == GF_MODE) mode_q <= wr_data[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sent_q <= 1'b0;
         cur_q  <= '0;
      end else if (!busy_q) begin
         if (any) begin
            busy_q <= 1'b1;
            sent_q <= 1'b0;
            cur_q  <= sel;
         end
      end else begin
         if (tx_valid && tx_ready) sent_q <= 1'b1;
         if (fin) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
         end
      end
   end

   // Frame fields of the locked mailbox
   logic [ID_W-1:0]                  cur_id;
   logic                             cur_ide, cur_rtr;
   logic [DLC_W-1:0]                 cur_dlc;
   logic [MAX_BYTES-1:0][BYTE_W-1:0] cur_dat;

   always_comb begin
      cur_id  = '0;
      cur_ide = 1'b0;
      cur_rtr = 1'b0;
      cur_dlc = '0;
      cur_dat = '0;
      for (int m = 1; m <= NUM_MB; m++) begin
         if (cur_oh[m]) begin
            cur_id  = id_a[m];
            cur_ide = ide_a[m];
            cur_rtr = rtr_a[m];
            cur_dlc = dlc_a[m];
            cur_dat = dat_a[m];
         end
      end
   end

   can_txmb_trunc u_trunc (
      .dlc(cur_dlc), .dat_in(cur_dat), .len(tx_len), .dat_out(tx_data)
   );

   assign tx_valid = busy_q && !sent_q;
   assign tx_mbox  = cur_q;
   assign tx_id    = cur_id;
   assign tx_ide   = cur_ide;
   assign tx_rtr   = cur_rtr;
   assign tx_dlc   = cur_dlc;
   assign irq      = |((okflg_q | abflg_q) & ~mask_q);

   always_comb begin
      rd_data = '0;
      if (rd_mb == '0) begin
         case (rd_fld)
            GF_PEND:  rd_data = REG_W'({pend_q, 1'b0});
            GF_OKFLG: rd_data = REG_W'({okflg_q, 1'b0});
            GF_ABFLG: rd_data = REG_W'({abflg_q, 1'b0});
            GF_MASK:  rd_data = REG_W'({mask_q, 1'b0});
            GF_MODE:  rd_data = REG_W'(mode_q);
            default:  rd_data = '0;
         endcase
      end else begin
         rd_data = mb_rd;
      end
   end
endmodule

// File: rtl/can_txmb_sched_chk.sv
module can_txmb_sched_chk #(
   parameter  int NUM_MB = 15,
   localparam int MB_W   = $clog2(NUM_MB + 1)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [MB_W-1:0]   tx_mbox,
   input logic [28:0]       tx_id,
   input logic [3:0]        tx_len,
   input logic [63:0]       tx_data,
   input logic              res_valid,
   input logic              res_ok,
   input logic              busy,
   input logic              sent,
   input logic [MB_W-1:0]   cur,
   input logic [NUM_MB:1]   pend,
   input logic [NUM_MB:1]   okflg,
   input logic [NUM_MB:1]   abflg
);
   a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_mbox) && $stable(tx_id) && $stable(tx_len));

   a_r6_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> pend[tx_mbox]);

   a_r5_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> tx_len <= 4'd8);

   a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_data >> {tx_len, 3'b000}) == 64'd0);

   a_r7_ok_flag: assert property (@(posedge clk) disable iff (!rst_n)
      busy && sent && res_valid && res_ok |=> okflg[$past(cur)]);

   a_r8_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
      busy && sent && res_valid && !res_ok |=> abflg[$past(cur)]);
endmodule

bind can_txmb_sched can_txmb_sched_chk #(.NUM_MB(NUM_MB)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
   .tx_mbox(tx_mbox), .tx_id(tx_id), .tx_len(tx_len), .tx_data(tx_data),
   .res_valid(res_valid), .res_ok(res_ok), .busy(busy_q), .sent(sent_q),
   .cur(cur_q), .pend(pend_q), .okflg(okflg_q), .abflg(abflg_q)
);

// File: tb/can_txmb_sched_tb.sv
module can_txmb_sched_tb;
   localparam int NMB = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        tx_valid, tx_ready = 1'b0;
   logic [3:0]  tx_mbox;
   logic [28:0] tx_id;
   logic        tx_ide, tx_rtr;
   logic [3:0]  tx_dlc, tx_len;
   logic [63:0] tx_data;
   logic        res_valid = 1'b0, res_ok = 1'b0;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   can_txmb_sched #(.NUM_MB(NMB)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_mbox(tx_mbox), .tx_id(tx_id), .tx_ide(tx_ide), .tx_rtr(tx_rtr),
      .tx_dlc(tx_dlc), .tx_len(tx_len), .tx_data(tx_data),
      .res_valid(res_valid), .res_ok(res_ok), .irq(irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] adr(input int mb, input int fld);
      return {4'(mb), 4'(fld)};
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   // Waits for an offer, checks the mailbox, holds off one cycle, accepts, reports.
   task automatic serve(input string req, input int exp_mb, input bit ok);
      logic [3:0] first;
      for (int k = 0; k < 20 && !tx_valid; k++) @(negedge clk);
      chk(req, "offer valid", 64'(tx_valid), 64'd1);
      chk(req, "offered mailbox", 64'(tx_mbox), 64'(exp_mb));
      first = tx_mbox;
      @(negedge clk);
      chk("R6", "held offer", 64'({tx_valid, tx_mbox}), 64'({1'b1, first}));
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      @(negedge clk);
      chk("R6", "no re-offer while locked", 64'(tx_valid), 64'd0);
      res_valid = 1'b1; res_ok = ok;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   function automatic logic [31:0] bkey(input int base, input int ext, input bit ide, input bit rtr);
      if (ide) return 32'(base) * 32'h20_0000 + 32'h10_0000 + 32'h8_0000 + 32'(ext) * 2 + 32'(rtr);
      else     return 32'(base) * 32'h20_0000 + 32'(rtr) * 32'h10_0000;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [63:0] expd;
      int base [1:NMB];
      int ext  [1:NMB];
      bit ide  [1:NMB];
      bit rtr  [1:NMB];
      logic [NMB:1] left;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int f = 0; f < 6; f++) begin
         rd(adr(0, f), d);
         chk("R1", "global reg after reset", 64'(d), 64'd0);
      end
      rd(adr(1, 0), d);
      chk("R1", "mailbox id after reset", 64'(d), 64'd0);
      chk("R1", "tx_valid after reset", 64'(tx_valid), 64'd0);
      chk("R1", "irq after reset", 64'(irq), 64'd0);

      // R5 sweep of every length code on mailbox 1
      for (int k = 0; k < 8; k++) wr(adr(1, 2 + k), 32'(8'h11 * (k + 1)));
      for (int c = 0; c < 16; c++) begin
         wr(adr(1, 1), 32'(c));
         wr(adr(0, 0), 32'h2);
         for (int k = 0; k < 20 && !tx_valid; k++) @(negedge clk);
         expd = '0;
         for (int k = 0; k < 8; k++)
            if (k < (c > 8 ? 8 : c)) expd[k*8 +: 8] = 8'(8'h11 * (k + 1));
         chk("R5", "tx_len", 64'(tx_len), 64'(c > 8 ? 8 : c));
         chk("R5", "tx_dlc", 64'(tx_dlc), 64'(c));
         chk("R5", "tx_data", tx_data, expd);
         serve("R5", 1, 1'b1);
      end
      rd(adr(0, 0), d);
      chk("R7", "pending cleared", 64'(d), 64'd0);
      rd(adr(0, 2), d);
      chk("R7", "success flag 1", 64'(d), 64'h2);

      // R11 clear, zero write no effect first
      wr(adr(0, 2), 32'h0);
      rd(adr(0, 2), d);
      chk("R11", "zero write keeps flag", 64'(d), 64'h2);
      wr(adr(0, 2), 32'hFFFF);
      rd(adr(0, 2), d);
      chk("R11", "flag cleared", 64'(d), 64'd0);

      // R3 number order, all mailboxes pending at once
      wr(adr(0, 5), 32'h1);
      wr(adr(0, 0), 32'hFFFE);
      for (int m = 1; m <= NMB; m++) serve("R3", m, 1'b1);
      rd(adr(0, 2), d);
      chk("R7", "all success flags", 64'(d), 64'hFFFE);
      wr(adr(0, 2), 32'hFFFE);

      // R4 identifier order with mixed formats and a tie (12 copies 5)
      wr(adr(0, 5), 32'h0);
      for (int m = 1; m <= NMB; m++) begin
         int src;
         src = (m == 12) ? 5 : m;
         base[m] = ((src * 5) % 7) * 100;
         ext[m]  = ((src * 29) % 5) * 1000 + src;
         ide[m]  = (src % 3 == 0);
         rtr[m]  = src[0];
         wr(adr(m, 0), {1'b0, ide[m], rtr[m], 11'(base[m]), 18'(ext[m])});
      end
      wr(adr(0, 0), 32'hFFFE);
      left = '1;
      for (int n = 0; n < NMB; n++) begin
         int best;
         best = 0;
         for (int m = 1; m <= NMB; m++)
            if (left[m] && (best == 0 ||
                bkey(base[m], ext[m], ide[m], rtr[m]) < bkey(base[best], ext[best], ide[best], rtr[best])))
               best = m;
         left[best] = 1'b0;
         for (int k = 0; k < 20 && !tx_valid; k++) @(negedge clk);
         chk("R4", "format bits", 64'({tx_ide, tx_rtr}), 64'({ide[best], rtr[best]}));
         chk("R4", "base id", 64'(tx_id[28:18]), 64'(base[best]));
         serve("R4", best, 1'b1);
      end
      wr(adr(0, 2), 32'hFFFE);

      // R9 abort register: 2 locked, 4 waiting; R2 zero write no effect
      wr(adr(0, 5), 32'h1);
      wr(adr(0, 0), 32'h14);
      wr(adr(0, 0), 32'h0);
      rd(adr(0, 0), d);
      chk("R2", "zero write keeps pending", 64'(d), 64'h14);
      wr(adr(0, 1), 32'h14);
      rd(adr(0, 0), d);
      chk("R9", "locked kept, waiting removed", 64'(d), 64'h4);
      rd(adr(0, 3), d);
      chk("R9", "abort flag only for waiting", 64'(d), 64'h10);
      serve("R9", 2, 1'b1);
      rd(adr(0, 2), d);
      chk("R7", "locked mailbox completed", 64'(d), 64'h4);

      // R8 transmitter abort result
      wr(adr(0, 0), 32'h8);
      serve("R8", 3, 1'b0);
      rd(adr(0, 0), d);
      chk("R8", "pending cleared on abort", 64'(d), 64'd0);
      rd(adr(0, 3), d);
      chk("R8", "abort flag set", 64'(d), 64'h18);

      // R10 interrupt masking
      chk("R10", "irq from abort flags", 64'(irq), 64'd1);
      wr(adr(0, 3), 32'hFFFE);
      wr(adr(0, 2), 32'hFFFE);
      #1 chk("R11", "irq after clearing", 64'(irq), 64'd0);
      wr(adr(0, 4), 32'h20);
      wr(adr(0, 0), 32'h20);
      serve("R10", 5, 1'b1);
      #1 chk("R10", "masked flag no irq", 64'(irq), 64'd0);
      wr(adr(0, 4), 32'h0);
      #1 chk("R10", "unmasked flag irq", 64'(irq), 64'd1);
      wr(adr(0, 2), 32'h20);
      #1 chk("R11", "irq drops after clear", 64'(irq), 64'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule